// File: doc/BRIEF.md
# Iterative Hamming Distance Unit

This block counts the bit positions at which two unsigned words disagree. When a request is accepted, it loads the exclusive-OR of the two words into a working register. On each following clock it removes the lowest set bit of that register and adds one to a tally. It stops when the working register reaches zero, and the tally at that point is the distance.

Because each cycle removes exactly one differing bit, the time taken follows the number of mismatches and not the word width. Words that are nearly equal finish in a few cycles. Complementary words take the longest. The caller raises `start` for one cycle with both operands while `busy` is low. It then waits for the one-cycle `done` pulse and reads `distance`, which stays put until the next accepted request.

Top module: `iter_hamming`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy` is 0, `done` is 0 and `distance` is 0.
- R2: The reported `distance` equals the count of bit positions where `op_a` and `op_b` differ; for example, 7'b1011101 against 7'b1001001 gives 2.
- R3: For a request with d differing bits accepted at clock edge k, `done` is high for exactly the cycle that follows edge k+d+1.
- R4: Identical operands produce `done` after the edge that follows the accepting edge, with `distance` 0.
- R5: Bitwise complementary operands produce `distance` equal to the word width `N`, with latency `N`+1 edges.
- R6: `done` never stays high for two consecutive cycles.
- R7: `distance` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R8: `start` is ignored while `busy` is high: no extra `done` pulse appears, and the result of the running request is not disturbed.
- R9: `busy` is high from the cycle after an accepted `start` through the cycle in which `done` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken only while idle |
| op_a | input | N | First operand word |
| op_b | input | N | Second operand word |
| busy | output | 1 | High while a request is in progress or being reported |
| done | output | 1 | One-cycle pulse when the result is ready |
| distance | output | $clog2(N+1) | Count of differing bit positions |

## Verification
A result for operands that differ in d positions is due d+2 cycles after the cycle in which the bench drives `start`: one edge loads the request, d edges each clear one bit, and a final edge detects zero. The driver works out this due cycle from a free-running cycle count and queues it with the expected distance. The monitor samples on falling edges and compares both the value and the arrival cycle whenever `done` is seen. Any pulse that arrives with an empty queue, or that lasts longer than one cycle, counts as a failure. This also covers requests that should have been ignored.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        HD_IDLE = 2'd0,
        HD_RUN  = 2'd1,
        HD_DONE = 2'd2
    } hd_state_e;

endpackage

// File: rtl/hd_lsb_clear.sv
module hd_lsb_clear #(
    parameter int W = 32
) (
    input  logic [W-1:0] value_in,
    output logic [W-1:0] value_out,
    output logic         is_zero
);

    always_comb begin
        value_out = value_in & (value_in - W'(1));
        is_zero   = (value_in == '0);
    end

endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
    import hd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic work_zero,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);

    typedef struct packed {
        hd_state_e state;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        unique case (r_q.state)
            HD_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    r_d.state = HD_RUN;
                end
            end
            HD_RUN: begin
                if (work_zero) begin
                    finish    = 1'b1;
                    r_d.state = HD_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            HD_DONE: r_d.state = HD_IDLE;
            default: r_d.state = HD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.state <= HD_IDLE;
        else     r_q <= r_d;
    end

    assign busy = (r_q.state != HD_IDLE);
    assign done = (r_q.state == HD_DONE);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/hd_datapath.sv
module hd_datapath #(
    parameter int N  = 32,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          finish,
    input  logic [N-1:0]  op_a,
    input  logic [N-1:0]  op_b,
    output logic          work_zero,
    output logic [CW-1:0] result
);

    typedef struct packed {
        logic [N-1:0]  work;
        logic [CW-1:0] tally;
        logic [CW-1:0] result;
    } dp_regs_t;

    dp_regs_t     r_q, r_d;
    logic [N-1:0] work_next;

    hd_lsb_clear #(.W(N)) i_clear (
        .value_in (r_q.work),
        .value_out(work_next),
        .is_zero  (work_zero)
    );

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.work  = op_a ^ op_b;
            r_d.tally = '0;
        end else if (step) begin
            r_d.work  = work_next;
            r_d.tally = r_q.tally + CW'(1);
        end
        if (finish) r_d.result = r_q.tally;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign result = r_q.result;

    a_r2_one_bit_per_step: assert property (@(posedge clk) disable iff (rst)
        step |=> ($countones(r_q.work) + 1 == $past($countones(r_q.work))));
    a_r5_tally_bound: assert property (@(posedge clk) disable iff (rst)
        r_q.tally <= CW'(N));
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(r_q.result));

endmodule

// File: rtl/iter_hamming.sv
module iter_hamming #(
    parameter int N  = 32,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [N-1:0]  op_a,
    input  logic [N-1:0]  op_b,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] distance
);

    logic load, step, finish, work_zero;

    hd_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .work_zero(work_zero),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .done     (done)
    );

    hd_datapath #(.N(N), .CW(CW)) i_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .op_a     (op_a),
        .op_b     (op_b),
        .work_zero(work_zero),
        .result   (distance)
    );

    a_r7_distance_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(distance) |-> done);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!busy && !done && distance == '0));

endmodule

// File: tb/test_iter_hamming.sv
module test_iter_hamming;

    localparam int N  = 32;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic          busy, done;
    logic [CW-1:0] distance;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_dist[$];
    int exp_cyc[$];
    int last_dist = 0;
    logic prev_done = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    iter_hamming #(.N(N)) i_iter_hamming (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .distance(distance)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as done pulses arrive
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done)
                check(1'b0, "R6 done longer than one cycle", 1, 0);
            if (done && !prev_done) begin
                if (exp_dist.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    int ed, ec;
                    ed = exp_dist.pop_front();
                    ec = exp_cyc.pop_front();
                    last_dist = ed;
                    check(distance == CW'(ed), "R2 distance value", distance, ed);
                    check(cyc == ec, "R3 done cycle", cyc, ec);
                    check(busy == 1'b1, "R9 busy during done", busy, 1);
                end
            end
            prev_done <= done;
        end
    end

    task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        exp_dist.push_back($countones(a ^ b));
        exp_cyc.push_back(cyc + $countones(a ^ b) + 2);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
    endtask

    task automatic drain();
        while (exp_dist.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", busy, 0);
        check(distance == '0, "R1 distance after reset", distance, 0);

        send(32'b1011101, 32'b1001001);          // R2 example: 2
        drain();
        send(32'hDEAD_BEEF, 32'hDEAD_BEEF);      // R4 identical
        drain();
        check(distance == '0, "R4 identical distance", distance, 0);
        send(32'h0F0F_00FF, ~32'h0F0F_00FF);     // R5 complement
        drain();
        check(distance == CW'(N), "R5 complement distance", distance, N);
        send(32'h8000_0000, 32'h0);              // single top bit
        send(32'h0000_0001, 32'h0);              // single low bit
        send(32'h1234_5678, 32'h8765_4321);
        send(32'hAAAA_AAAA, 32'h5555_0000);
        drain();

        // R8: start pulses while busy must be ignored
        send(32'h0000_00FF, 32'h0);
        start = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R8 no extra work started", busy, 0);
        check(distance == CW'(8), "R8 running result kept", distance, 8);

        // R7: result held across idle cycles
        send(32'h0000_F00F, 32'h0);
        drain();
        repeat (6) @(negedge clk);
        check(distance == CW'(last_dist), "R7 result held", distance, last_dist);
        check(done == 1'b0, "R6 done low when idle", done, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule